// File: doc/BRIEF.md
# Whole-Array Erase and Blank-Check Sequencer

This block runs on the programming-equipment side of a reprogrammable memory. After a start request it applies timed whole-array erase pulses and then reads the address window back byte by byte, expecting every byte to be all ones. An erase pulse is always the first action. No bytes are written to zero beforehand.

When a byte is not blank, its address is recorded and another pulse is applied. The following blank check resumes at that recorded address rather than at the bottom of the window. Bytes at and above the resume point are read first. The walk then wraps from the top of the window back to the bottom and rechecks the bytes below the resume point. A pass is only declared once every byte of the window has read blank in a single pass.

Two limits can end the run in failure:
- a cap on the number of pulses;
- a cap on the total pulse time.

A pulse that would break either cap is never issued.

Timing is given in clock cycles:
- pulse length;
- guard intervals around the high-voltage request and before each read strobe;
- the pulse-count cap and the total-time cap.

Generating the high voltage itself is outside this block.

Top module: `erase_verify_ctrl`

## Requirements
- R1: After `start`, the first bus action is an erase pulse. `oe_n` is never low before the first pulse of a run.
- R2: Each erase pulse holds `ce_n` low, with `hv_req` high, for exactly PULSE_CYC cycles. No more than MAX_PULSES pulses are issued per run. If a blank check fails when no further pulse is allowed, the run ends with `fail`.
- R3: The summed length of all pulses in a run never exceeds CAP_CYC cycles. When one more pulse would exceed CAP_CYC, that pulse is not issued and the run ends with `fail`.
- R4: The first blank check of a run starts at `addr_lo` and covers `addr_lo` to `addr_hi` inclusive. Addresses outside this window are never read. A byte passes only when `rd_data` equals 8'hFF; a byte with any single bit at zero fails.
- R5: On a failing byte, its address appears on `fail_addr`, a new pulse follows, and the next blank check starts at that address.
- R6: `hv_req` rises at least GUARD_CYC cycles before `ce_n` falls for a pulse. It stays high for at least GUARD_CYC cycles after `ce_n` rises at the end of the pulse.
- R7: `mem_addr` is unchanged for at least GUARD_CYC cycles before `oe_n` falls, and stays unchanged while `oe_n` is low. `ce_n` is low during blank-check reads.
- R8: A resumed check that reaches `addr_hi` wraps to `addr_lo` and rereads the bytes below its starting address. `pass` is given only after every byte of the window has read blank within one check.
- R9: `done` is high for exactly one cycle per run. With it, exactly one of `pass` and `fail` is high, and `pulses_used` and `fail_addr` are valid. `fail_addr` is 0 when no byte failed in the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken while idle) |
| addr_lo | input | AW | Lowest address of the window |
| addr_hi | input | AW | Highest address of the window |
| rd_data | input | DW | Byte read from the memory |
| mem_addr | output | AW | Address to the memory |
| ce_n | output | 1 | Active-low chip select / pulse strobe |
| oe_n | output | 1 | Active-low read strobe |
| hv_req | output | 1 | Request for erase high voltage on the identifier line |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Window verified blank |
| fail | output | 1 | Gave up without a blank window |
| pulses_used | output | $clog2(MAX_PULSES+1) | Pulses issued in this run |
| fail_addr | output | AW | Most recent failing address (0 if none) |

## Verification
The bench builds two instances, each with a 16-byte address space.

The first instance uses:
- 4-cycle pulses and 2-cycle guards;
- a cap of 10 pulses;
- a total-time cap of 26 cycles.

With these values the time cap binds at six pulses, before the count cap does. This selects the time-tracking variant and makes both "pass on the sixth pulse" and "refused seventh pulse" reachable.

The second instance uses:
- 3-cycle pulses and 1-cycle guards;
- a cap of 3 pulses;
- a total-time cap large enough never to bind.

This selects the count-only variant and ends runs on the pulse cap.

The small space lets a bench model of per-byte erase thresholds drive resume and wrap-around walks that a tally of reads per address can confirm.

// File: rtl/erz_pkg.sv
package erz_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DECIDE,
      ST_HV_RISE,
      ST_PULSE,
      ST_HV_FALL,
      ST_SETUP,
      ST_READ
   } erz_state_e;

endpackage

// File: rtl/erz_phase_timer.sv
module erz_phase_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/erz_budget.sv
module erz_budget #(
   parameter int unsigned MAX_PULSES = 10,
   parameter int unsigned PULSE_CYC  = 4,
   parameter int unsigned CAP_CYC    = 30
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                clr,
   input  logic                                take,
   output logic [$clog2(MAX_PULSES+1)-1:0]     count,
   output logic                                may_issue
);

   localparam int unsigned PW         = $clog2(MAX_PULSES + 1);
   localparam bit          TIME_BINDS = (CAP_CYC < MAX_PULSES * PULSE_CYC);

   logic count_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (take)
         count <= count + 1'b1;
   end

   assign count_ok = (count < PW'(MAX_PULSES));

   assert_pulse_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PW'(MAX_PULSES));

   generate
      if (TIME_BINDS) begin : g_timed
         localparam int unsigned TW = $clog2(CAP_CYC + PULSE_CYC + 1);
         localparam logic [TW-1:0] PULSE_W = TW'(PULSE_CYC);
         localparam logic [TW-1:0] CAP_W   = TW'(CAP_CYC);
         logic [TW-1:0] total_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               total_q <= '0;
            else if (clr)
               total_q <= '0;
            else if (take)
               total_q <= total_q + PULSE_W;
         end

         assign may_issue = count_ok && ((total_q + PULSE_W) <= CAP_W);

         assert_time_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            total_q <= CAP_W);
      end else begin : g_count_only
         assign may_issue = count_ok;
      end
   endgenerate

endmodule

// File: rtl/erz_addr_walk.sv
module erz_addr_walk #(
   parameter int unsigned AW = 19
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic [AW-1:0] lo_in,
   input  logic [AW-1:0] hi_in,
   input  logic          begin_pass,
   input  logic          advance,
   input  logic          mark_fail,
   output logic [AW-1:0] cur,
   output logic [AW-1:0] fail_addr,
   output logic          last_byte
);

   logic [AW-1:0] lo_q, hi_q, resume_q;
   logic [AW:0]   span, seen_q;

   assign span      = {1'b0, hi_q} - {1'b0, lo_q} + 1'b1;
   assign last_byte = ((seen_q + 1'b1) == span);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q      <= '0;
         hi_q      <= '0;
         resume_q  <= '0;
         cur       <= '0;
         fail_addr <= '0;
         seen_q    <= '0;
      end else if (init) begin
         lo_q      <= lo_in;
         hi_q      <= hi_in;
         resume_q  <= lo_in;
         cur       <= lo_in;
         fail_addr <= '0;
         seen_q    <= '0;
      end else begin
         if (begin_pass) begin
            cur    <= resume_q;
            seen_q <= '0;
         end else if (advance) begin
            cur    <= (cur == hi_q) ? lo_q : cur + 1'b1;
            seen_q <= seen_q + 1'b1;
         end
         if (mark_fail) begin
            resume_q  <= cur;
            fail_addr <= cur;
         end
      end
   end

   assert_walk_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_q <= hi_q) |-> ((cur >= lo_q) && (cur <= hi_q)));

endmodule

// File: rtl/erase_verify_ctrl.sv
module erase_verify_ctrl #(
   parameter int unsigned AW         = 19,
   parameter int unsigned DW         = 8,
   parameter int unsigned PULSE_CYC  = 5_000_000,
   parameter int unsigned GUARD_CYC  = 20,
   parameter int unsigned MAX_PULSES = 10,
   parameter int unsigned CAP_CYC    = 30_000_000
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [AW-1:0]                     addr_lo,
   input  logic [AW-1:0]                     addr_hi,
   input  logic [DW-1:0]                     rd_data,
   output logic [AW-1:0]                     mem_addr,
   output logic                              ce_n,
   output logic                              oe_n,
   output logic                              hv_req,
   output logic                              done,
   output logic                              pass,
   output logic                              fail,
   output logic [$clog2(MAX_PULSES+1)-1:0]   pulses_used,
   output logic [AW-1:0]                     fail_addr
);

   import erz_pkg::*;

   localparam int unsigned LONGEST = (PULSE_CYC > GUARD_CYC) ? PULSE_CYC : GUARD_CYC;
   localparam int unsigned TMW     = $clog2(LONGEST + 1);
   localparam logic [TMW-1:0] PULSE_LD = TMW'(PULSE_CYC - 1);
   localparam logic [TMW-1:0] GUARD_LD = TMW'(GUARD_CYC - 1);
   localparam logic [DW-1:0]  BLANK    = '1;

   generate
      if (PULSE_CYC < 1)  begin : g_bad_pulse  $error("PULSE_CYC must be at least 1");  end
      if (GUARD_CYC < 1)  begin : g_bad_guard  $error("GUARD_CYC must be at least 1");  end
      if (MAX_PULSES < 1) begin : g_bad_max    $error("MAX_PULSES must be at least 1"); end
      if (CAP_CYC < PULSE_CYC) begin : g_bad_cap $error("CAP_CYC below one pulse"); end
      if (AW < 1 || DW < 1) begin : g_bad_width $error("AW and DW must be positive"); end
   endgenerate

   erz_state_e st_q, st_d;
   logic tmr_load, tmr_done;
   logic [TMW-1:0] tmr_val;
   logic walk_init, walk_begin, walk_adv, walk_fail, walk_last;
   logic bud_clr, bud_take, bud_ok;
   logic end_pass, end_fail;

   erz_phase_timer #(.W(TMW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_done)
   );

   erz_budget #(.MAX_PULSES(MAX_PULSES), .PULSE_CYC(PULSE_CYC), .CAP_CYC(CAP_CYC)) u_budget (
      .clk(clk), .rst_n(rst_n), .clr(bud_clr), .take(bud_take),
      .count(pulses_used), .may_issue(bud_ok)
   );

   erz_addr_walk #(.AW(AW)) u_walk (
      .clk(clk), .rst_n(rst_n), .init(walk_init), .lo_in(addr_lo), .hi_in(addr_hi),
      .begin_pass(walk_begin), .advance(walk_adv), .mark_fail(walk_fail),
      .cur(mem_addr), .fail_addr(fail_addr), .last_byte(walk_last)
   );

   always_comb begin
      st_d       = st_q;
      tmr_load   = 1'b0;
      tmr_val    = GUARD_LD;
      walk_init  = 1'b0;
      walk_begin = 1'b0;
      walk_adv   = 1'b0;
      walk_fail  = 1'b0;
      bud_clr    = 1'b0;
      bud_take   = 1'b0;
      end_pass   = 1'b0;
      end_fail   = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start) begin
            walk_init = 1'b1;
            bud_clr   = 1'b1;
            st_d      = ST_DECIDE;
         end
         ST_DECIDE: if (bud_ok) begin
            bud_take = 1'b1;
            tmr_load = 1'b1;
            st_d     = ST_HV_RISE;
         end else begin
            end_fail = 1'b1;
            st_d     = ST_IDLE;
         end
         ST_HV_RISE: if (tmr_done) begin
            tmr_load = 1'b1;
            tmr_val  = PULSE_LD;
            st_d     = ST_PULSE;
         end
         ST_PULSE: if (tmr_done) begin
            tmr_load = 1'b1;
            st_d     = ST_HV_FALL;
         end
         ST_HV_FALL: if (tmr_done) begin
            walk_begin = 1'b1;
            tmr_load   = 1'b1;
            st_d       = ST_SETUP;
         end
         ST_SETUP: if (tmr_done) st_d = ST_READ;
         ST_READ: if (rd_data == BLANK) begin
            walk_adv = 1'b1;
            if (walk_last) begin
               end_pass = 1'b1;
               st_d     = ST_IDLE;
            end else begin
               tmr_load = 1'b1;
               st_d     = ST_SETUP;
            end
         end else begin
            walk_fail = 1'b1;
            st_d      = ST_DECIDE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         done <= 1'b0;
         pass <= 1'b0;
         fail <= 1'b0;
      end else begin
         st_q <= st_d;
         done <= end_pass | end_fail;
         if (walk_init) begin
            pass <= 1'b0;
            fail <= 1'b0;
         end else if (end_pass | end_fail) begin
            pass <= end_pass;
            fail <= end_fail;
         end
      end
   end

   assign hv_req = (st_q == ST_HV_RISE) || (st_q == ST_PULSE) || (st_q == ST_HV_FALL);
   assign ce_n   = !((st_q == ST_PULSE) || (st_q == ST_SETUP) || (st_q == ST_READ));
   assign oe_n   = (st_q != ST_READ);

   assert_hv_leads_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ce_n) && hv_req) |-> $past(hv_req));

   assert_hv_trails_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ce_n) && $past(hv_req)) |-> hv_req);

   assert_addr_held_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> $stable(mem_addr));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass != fail));

endmodule

// File: tb/sim_erase_verify_ctrl.sv
module sim_erase_verify_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int G0 = 2;
   localparam int P0 = 4;

   typedef struct packed {
      logic [3:0] lo;
      logic [3:0] hi;
      logic [3:0] pa;
      logic [3:0] na;
      logic [3:0] pb;
      logic [3:0] nb;
      logic       exp_pass;
      logic [3:0] exp_pulses;
      logic [3:0] exp_faddr;
   } vec_t;

   // Each byte needs 1 pulse except pa (na pulses) and pb (nb pulses).
   localparam vec_t VTAB [7] = '{
      '{4'd0, 4'd15, 4'd0,  4'd1, 4'd0, 4'd1, 1'b1, 4'd1, 4'd0},
      '{4'd0, 4'd15, 4'd5,  4'd2, 4'd5, 4'd2, 1'b1, 4'd2, 4'd5},
      '{4'd0, 4'd15, 4'd9,  4'd3, 4'd3, 4'd2, 1'b1, 4'd3, 4'd9},
      '{4'd0, 4'd15, 4'd12, 4'd4, 4'd2, 4'd3, 1'b1, 4'd4, 4'd12},
      '{4'd0, 4'd15, 4'd7,  4'd7, 4'd7, 4'd7, 1'b0, 4'd6, 4'd7},
      '{4'd0, 4'd15, 4'd7,  4'd6, 4'd7, 4'd6, 1'b1, 4'd6, 4'd7},
      '{4'd3, 4'd10, 4'd2,  4'd9, 4'd8, 4'd2, 1'b1, 4'd2, 4'd8}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int tests = 0;
   int fails = 0;

   // instance u0: time cap binds
   logic       start0 = 1'b0;
   logic [3:0] lo0 = '0, hi0 = '0;
   logic [7:0] rd0;
   logic [3:0] addr0, faddr0, pu0;
   logic       ce0, oe0, hv0, done0, pass0, fail0;

   erase_verify_ctrl #(.AW(4), .DW(8), .PULSE_CYC(P0), .GUARD_CYC(G0),
                       .MAX_PULSES(10), .CAP_CYC(26)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start0), .addr_lo(lo0), .addr_hi(hi0),
      .rd_data(rd0), .mem_addr(addr0), .ce_n(ce0), .oe_n(oe0), .hv_req(hv0),
      .done(done0), .pass(pass0), .fail(fail0), .pulses_used(pu0), .fail_addr(faddr0)
   );

   // instance u1: pulse-count cap binds
   logic       start1 = 1'b0;
   logic [7:0] rd1;
   logic [3:0] addr1, faddr1;
   logic [1:0] pu1;
   logic       ce1, oe1, hv1, done1, pass1, fail1;

   erase_verify_ctrl #(.AW(4), .DW(8), .PULSE_CYC(3), .GUARD_CYC(1),
                       .MAX_PULSES(3), .CAP_CYC(1000)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start1), .addr_lo(4'd0), .addr_hi(4'd15),
      .rd_data(rd1), .mem_addr(addr1), .ce_n(ce1), .oe_n(oe1), .hv_req(hv1),
      .done(done1), .pass(pass1), .fail(fail1), .pulses_used(pu1), .fail_addr(faddr1)
   );

   // memory models: byte reads 8'hFF once its pulse threshold is met,
   // otherwise all ones with a single bit cleared
   int need0 [16];
   int need1 [16];
   int pulses0 = 0, pulses1 = 0;
   int reads0 [16];
   int tviol0 = 0, r1viol0 = 0;

   always_comb begin
      if (!oe0)
         rd0 = (pulses0 >= need0[addr0]) ? 8'hFF : (8'hFF & ~(8'h01 << addr0[2:0]));
      else
         rd0 = 8'h00;
      if (!oe1)
         rd1 = (pulses1 >= need1[addr1]) ? 8'hFF : (8'hFF & ~(8'h01 << addr1[2:0]));
      else
         rd1 = 8'h00;
   end

   logic prev_ce0 = 1'b1, prev_hv0 = 1'b0, prev_oe0 = 1'b1, prev_ce1 = 1'b1;
   logic [3:0] prev_addr0 = '0;
   int hv_cnt = 0, low_cnt = 0, tail_cnt = 0, stab = 0;
   bit in_tail = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!ce0 && hv0 && prev_ce0) begin
            pulses0 = pulses0 + 1;
            if (hv_cnt < G0) tviol0 = tviol0 + 1;
            low_cnt = 0;
         end
         if (hv0 && ce0) hv_cnt = hv_cnt + 1;
         else if (!hv0) hv_cnt = 0;
         if (!ce0 && hv0) low_cnt = low_cnt + 1;
         if (ce0 && !prev_ce0 && prev_hv0) begin
            if (low_cnt != P0) tviol0 = tviol0 + 1;
            in_tail  = 1'b1;
            tail_cnt = 0;
         end
         if (in_tail) begin
            if (hv0 && ce0) tail_cnt = tail_cnt + 1;
            else begin
               if (tail_cnt < G0) tviol0 = tviol0 + 1;
               in_tail = 1'b0;
            end
         end
         if (addr0 == prev_addr0) stab = stab + 1;
         else stab = 1;
         if (!oe0 && prev_oe0) begin
            if (stab - 1 < G0) tviol0 = tviol0 + 1;
            if (ce0) tviol0 = tviol0 + 1;
         end
         if (!oe0) begin
            reads0[addr0] = reads0[addr0] + 1;
            if (pulses0 == 0) r1viol0 = r1viol0 + 1;
         end
         if (!ce1 && hv1 && prev_ce1) pulses1 = pulses1 + 1;
         prev_ce0   = ce0;
         prev_hv0   = hv0;
         prev_oe0   = oe0;
         prev_addr0 = addr0;
         prev_ce1   = ce1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests = tests + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run0(input vec_t v, input int idx);
      int n;
      for (int i = 0; i < 16; i++) begin
         need0[i]  = 1;
         reads0[i] = 0;
      end
      need0[v.pa] = v.na;
      need0[v.pb] = v.nb;
      pulses0 = 0;
      tviol0  = 0;
      r1viol0 = 0;
      @(negedge clk);
      lo0 = v.lo;
      hi0 = v.hi;
      start0 = 1'b1;
      @(negedge clk);
      start0 = 1'b0;
      n = 0;
      while (!done0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(done0 == 1'b1, "R9", $sformatf("vec%0d done seen", idx), done0, 1);
      chk(pass0 == v.exp_pass, "R8", $sformatf("vec%0d pass", idx), pass0, v.exp_pass);
      chk(fail0 == !v.exp_pass, "R2", $sformatf("vec%0d fail", idx), fail0, !v.exp_pass);
      chk(pu0 == v.exp_pulses, "R3", $sformatf("vec%0d pulses_used", idx), pu0, v.exp_pulses);
      chk(faddr0 == v.exp_faddr, "R5", $sformatf("vec%0d fail_addr", idx), faddr0, v.exp_faddr);
      chk(pulses0 == v.exp_pulses, "R2", $sformatf("vec%0d pulses on bus", idx), pulses0, v.exp_pulses);
      chk(tviol0 == 0, "R6", $sformatf("vec%0d guard/pulse/setup violations", idx), tviol0, 0);
      chk(r1viol0 == 0, "R1", $sformatf("vec%0d reads before first pulse", idx), r1viol0, 0);
      @(negedge clk);
      chk(done0 == 1'b0, "R9", $sformatf("vec%0d done one cycle", idx), done0, 0);
   endtask

   task automatic run1(input int need_at1, input bit exp_pass, input int exp_pu);
      int n;
      for (int i = 0; i < 16; i++) need1[i] = 1;
      need1[1] = need_at1;
      pulses1 = 0;
      @(negedge clk);
      start1 = 1'b1;
      @(negedge clk);
      start1 = 1'b0;
      n = 0;
      while (!done1 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(done1 == 1'b1, "R9", "u1 done seen", done1, 1);
      chk(pass1 == exp_pass, "R2", "u1 pass", pass1, exp_pass);
      chk(fail1 == !exp_pass, "R2", "u1 fail", fail1, !exp_pass);
      chk(pu1 == exp_pu, "R2", "u1 pulses_used", pu1, exp_pu);
      chk(faddr1 == 4'd1, "R5", "u1 fail_addr", faddr1, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL R9 watchdog expired: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         need0[i]  = 1;
         need1[i]  = 1;
         reads0[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R9)
      chk(done0 == 0 && pass0 == 0 && fail0 == 0, "R9", "reset status", {done0, pass0, fail0}, 0);
      chk(ce0 && oe0 && !hv0, "R6", "reset strobes idle", {ce0, oe0, hv0}, 6);
      chk(pu0 == 0 && faddr0 == 0, "R9", "reset counters", pu0, 0);

      for (int k = 0; k < 7; k++) begin
         run0(VTAB[k], k);
         if (k == 1) begin
            // R8: resume at 5, wrap back and recheck 0..4
            chk(reads0[0] == 2, "R8", "vec1 reads of addr 0", reads0[0], 2);
            chk(reads0[5] == 2, "R8", "vec1 reads of addr 5", reads0[5], 2);
            chk(reads0[15] == 1, "R8", "vec1 reads of addr 15", reads0[15], 1);
         end
         if (k == 2)
            chk(reads0[4] == 2, "R5", "vec2 addr 4 reads (pass 3 resumes at 9)", reads0[4], 2);
         if (k == 6) begin
            // R4: window 3..10 only
            chk(reads0[2] == 0, "R4", "vec6 reads below window", reads0[2], 0);
            chk(reads0[11] == 0, "R4", "vec6 reads above window", reads0[11], 0);
            chk(reads0[3] == 2, "R8", "vec6 wrap to window bottom", reads0[3], 2);
         end
      end

      run1(4, 1'b0, 3);
      run1(3, 1'b1, 3);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule